// File: doc/BRIEF.md
# Asynchronous SRAM Controller

This block lets a clocked host read and write an asynchronous static RAM of 128K bytes. The RAM has two chip enables, one active low and one active high, a write strobe, an output enable, a 17-bit address and an 8-bit data bus. The controller keeps the RAM deselected while it is idle. For each host request it runs one strobe sequence, and every interval in that sequence is a whole number of clock cycles. Each cycle count comes from a nanosecond parameter divided by the clock period and rounded up, with a minimum of one cycle. The count for the time to high impedance after a read is used as the bus turnaround.

The host uses a valid/ready request channel. The host holds `req_valid` together with the operation, address and write data until it sees `req_ready` high at a rising clock edge. `req_ready` is high only while the controller is idle, so the controller has at most one access in flight. The response has no back-pressure: `rsp_valid` is high for exactly one clock, and the host must take `rsp_rdata` in that cycle. For writes the pulse only reports that the write has finished.

The data bus is split into `sram_dq_out`, `sram_dq_oe` and `sram_dq_in`. The chip-level pad combines them into the bidirectional pins.

Top module: `asram_ctrl`

## Requirements
- R1: During reset and whenever the controller is idle, it holds the RAM in standby (`sram_ce1_n`=1, `sram_ce2`=0, `sram_we_n`=1, `sram_oe_n`=1), does not drive the data bus (`sram_dq_oe`=0) and raises `req_ready`.
- R2: A request is accepted only at a rising edge where `req_valid` and `req_ready` are both high. `req_ready` then stays low until the controller is idle again. Changes to the request inputs while it is low have no effect on the access in progress.
- R3: A read holds `sram_ce1_n`=0, `sram_ce2`=1, `sram_oe_n`=0 and `sram_we_n`=1 for RD_CYC = max(ceil(tAA), ceil(tRC)) cycles. `sram_dq_in` is sampled at the last edge of that window. `rsp_valid` and the sampled byte on `rsp_rdata` appear RD_CYC edges after the accepting edge.
- R4: After a read, the controller deselects the RAM with OE high and stays busy for HZ_CYC = ceil(tOHZ) further cycles. `req_ready` returns RD_CYC+HZ_CYC edges after the accepting edge.
- R5: A write pulse holds `sram_ce1_n`=0, `sram_ce2`=1, `sram_we_n`=0 and `sram_oe_n`=1 for WP_CYC = max(ceil(tWP), ceil(tDS)) cycles. `sram_we_n` is never low unless both enables are active and OE is high.
- R6: `sram_dq_oe` is high only during a write pulse and its recovery. It is never high while `sram_oe_n` is low, and never before OE has been high for HZ_CYC cycles. `sram_dq_out` does not change while it is high.
- R7: After the pulse, a recovery of REC_CYC = max(ceil(tWR), WC_CYC−WP_CYC, 1) cycles keeps the address and data driven with the RAM deselected. `rsp_valid` and `req_ready` both rise WP_CYC+REC_CYC edges after the accepting edge.
- R8: `sram_addr` keeps the accepted address from the accepting edge until the next accepting edge.
- R9: `rsp_valid` is never high for two consecutive cycles, and each accepted request produces exactly one pulse.
- R10: Each cycle count is the parameter in ns divided by CLK_NS, rounded up, with a minimum of one cycle. With CLK_NS=20 and tWC=60 the write recovery is one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request taken at this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Last byte read |
| sram_ce1_n | output | 1 | Chip enable, active low |
| sram_ce2 | output | 1 | Chip enable, active high |
| sram_we_n | output | 1 | Write strobe, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_addr | output | ADDR_W | RAM address |
| sram_dq_out | output | DATA_W | Data toward the RAM |
| sram_dq_oe | output | 1 | Data bus drive enable |
| sram_dq_in | input | DATA_W | Data from the RAM |

## Verification
Several properties are checked by assertions on every cycle:
- the strobe combinations that may never occur: WE low without both enables or with OE low, and the bus driven while OE is low;
- the standby state while the controller is ready;
- address and write-data stability while busy;
- the single-cycle response;
- the minimum write pulse and the turnaround after OE rises, each measured with a counter in the checker.

Other behaviour only the bench scenarios can show. They cover the exact latencies and that read data is sampled no earlier than the access time. A RAM model in the bench returns wrong data before then, commits a write only when the pulse and data-setup widths are met, and flags contention on the bus. They also cover full address sweeps in several orders and that request inputs changed while busy are ignored.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_RD_ACC   = 3'd1,
    ST_RD_HIZ   = 3'd2,
    ST_WR_PULSE = 3'd3,
    ST_WR_REC   = 3'd4
  } asram_state_e;

  typedef struct packed {
    logic ce1_n;
    logic ce2;
    logic we_n;
    logic oe_n;
    logic dq_oe;
  } asram_pins_t;

  localparam asram_pins_t PINS_STANDBY = '{ce1_n: 1'b1, ce2: 1'b0, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0};

  // Convert a nanosecond interval to clock cycles, rounding up, at least one.
  function automatic int ns_to_cyc(input int t_ns, input int clk_ns);
    int c;
    c = (t_ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Recovery length: write recovery, or whatever remains of the cycle time.
  function automatic int rec_cycles(input int wr_cyc, input int wc_cyc, input int wp_cyc);
    int rest;
    rest = (wc_cyc > wp_cyc) ? (wc_cyc - wp_cyc) : 0;
    return imax(imax(wr_cyc, rest), 1);
  endfunction

  // Strobe levels to present while in a given state.
  function automatic asram_pins_t pins_for(input asram_state_e s);
    asram_pins_t p;
    p = PINS_STANDBY;
    case (s)
      ST_RD_ACC: begin
        p.ce1_n = 1'b0; p.ce2 = 1'b1; p.oe_n = 1'b0;
      end
      ST_WR_PULSE: begin
        p.ce1_n = 1'b0; p.ce2 = 1'b1; p.we_n = 1'b0; p.dq_oe = 1'b1;
      end
      ST_WR_REC: begin
        p.dq_oe = 1'b1;
      end
      default: p = PINS_STANDBY;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/asram_timer.sv
module asram_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/asram_fsm.sv
module asram_fsm
  import asram_pkg::*;
#(
  parameter int CNT_W   = 4,
  parameter int RD_CYC  = 13,
  parameter int HZ_CYC  = 5,
  parameter int WP_CYC  = 10,
  parameter int REC_CYC = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             tmr_done,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             req_ready,
  output logic             accept,
  output logic             capture,
  output logic             rsp_pulse,
  output asram_pins_t      pins
);
  localparam logic [CNT_W-1:0] RD_LD  = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] HZ_LD  = CNT_W'(HZ_CYC - 1);
  localparam logic [CNT_W-1:0] WP_LD  = CNT_W'(WP_CYC - 1);
  localparam logic [CNT_W-1:0] REC_LD = CNT_W'(REC_CYC - 1);

  asram_state_e state_q, state_d;
  logic         wr_done;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    accept   = 1'b0;
    capture  = 1'b0;
    wr_done  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          accept   = 1'b1;
          tmr_load = 1'b1;
          if (req_write) begin
            state_d = ST_WR_PULSE;
            tmr_val = WP_LD;
          end else begin
            state_d = ST_RD_ACC;
            tmr_val = RD_LD;
          end
        end
      end
      ST_RD_ACC: begin
        if (tmr_done) begin
          capture  = 1'b1;
          state_d  = ST_RD_HIZ;
          tmr_load = 1'b1;
          tmr_val  = HZ_LD;
        end
      end
      ST_RD_HIZ: begin
        if (tmr_done) state_d = ST_IDLE;
      end
      ST_WR_PULSE: begin
        if (tmr_done) begin
          state_d  = ST_WR_REC;
          tmr_load = 1'b1;
          tmr_val  = REC_LD;
        end
      end
      ST_WR_REC: begin
        if (tmr_done) begin
          wr_done = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      pins      <= PINS_STANDBY;
      rsp_pulse <= 1'b0;
    end else begin
      state_q   <= state_d;
      pins      <= pins_for(state_d);
      rsp_pulse <= capture | wr_done;
    end
  end

  assign req_ready = (state_q == ST_IDLE);
endmodule

// File: rtl/asram_datapath.sv
module asram_datapath #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] dq_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] rdata_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      if (capture) rdata_q <= dq_in;
    end
  end
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int DATA_W   = 8,
  parameter int CLK_NS   = 8,
  parameter int T_RC_NS  = 100,
  parameter int T_AA_NS  = 100,
  parameter int T_OHZ_NS = 35,
  parameter int T_WC_NS  = 100,
  parameter int T_WP_NS  = 75,
  parameter int T_DS_NS  = 40,
  parameter int T_WR_NS  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              sram_ce1_n,
  output logic              sram_ce2,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_in
);
  localparam int RD_CYC  = imax(ns_to_cyc(T_AA_NS, CLK_NS), ns_to_cyc(T_RC_NS, CLK_NS));
  localparam int HZ_CYC  = ns_to_cyc(T_OHZ_NS, CLK_NS);
  localparam int WP_CYC  = imax(ns_to_cyc(T_WP_NS, CLK_NS), ns_to_cyc(T_DS_NS, CLK_NS));
  localparam int REC_CYC = rec_cycles(ns_to_cyc(T_WR_NS, CLK_NS), ns_to_cyc(T_WC_NS, CLK_NS), WP_CYC);
  localparam int MAX_CYC = imax(imax(RD_CYC, HZ_CYC), imax(WP_CYC, REC_CYC));
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic             tmr_load, tmr_done, accept, capture;
  logic [CNT_W-1:0] tmr_val;
  asram_pins_t      pins;

  asram_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  asram_fsm #(
    .CNT_W   (CNT_W),
    .RD_CYC  (RD_CYC),
    .HZ_CYC  (HZ_CYC),
    .WP_CYC  (WP_CYC),
    .REC_CYC (REC_CYC)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .tmr_done  (tmr_done),
    .tmr_load  (tmr_load),
    .tmr_val   (tmr_val),
    .req_ready (req_ready),
    .accept    (accept),
    .capture   (capture),
    .rsp_pulse (rsp_valid),
    .pins      (pins)
  );

  asram_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .capture   (capture),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .dq_in     (sram_dq_in),
    .addr_q    (sram_addr),
    .wdata_q   (sram_dq_out),
    .rdata_q   (rsp_rdata)
  );

  assign sram_ce1_n = pins.ce1_n;
  assign sram_ce2   = pins.ce2;
  assign sram_we_n  = pins.we_n;
  assign sram_oe_n  = pins.oe_n;
  assign sram_dq_oe = pins.dq_oe;
endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8,
  parameter int WP_CYC = 10,
  parameter int HZ_CYC = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              sram_ce1_n,
  input logic              sram_ce2,
  input logic              sram_we_n,
  input logic              sram_oe_n,
  input logic [ADDR_W-1:0] sram_addr,
  input logic [DATA_W-1:0] sram_dq_out,
  input logic              sram_dq_oe
);
  logic [15:0] we_lo_cnt, oe_hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_lo_cnt <= '0;
      oe_hi_cnt <= 16'(HZ_CYC);
    end else begin
      if (!sram_we_n) we_lo_cnt <= (we_lo_cnt >= 16'(WP_CYC)) ? we_lo_cnt : we_lo_cnt + 16'd1;
      else            we_lo_cnt <= '0;
      if (sram_oe_n)  oe_hi_cnt <= (oe_hi_cnt >= 16'(HZ_CYC)) ? oe_hi_cnt : oe_hi_cnt + 16'd1;
      else            oe_hi_cnt <= '0;
    end
  end

  // R1
  idle_standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (sram_ce1_n && !sram_ce2 && sram_we_n && sram_oe_n && !sram_dq_oe));

  // R5
  we_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> (!sram_ce1_n && sram_ce2 && sram_oe_n));

  // R5
  we_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> (we_lo_cnt >= 16'(WP_CYC)));

  // R6
  no_fight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sram_dq_oe |-> (sram_oe_n && oe_hi_cnt >= 16'(HZ_CYC)));

  // R6
  wdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sram_dq_oe |=> (!sram_dq_oe || $stable(sram_dq_out)));

  // R8
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> $stable(sram_addr));

  // R9
  single_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

bind asram_ctrl asram_ctrl_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .WP_CYC (WP_CYC),
  .HZ_CYC (HZ_CYC)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_ready   (req_ready),
  .rsp_valid   (rsp_valid),
  .sram_ce1_n  (sram_ce1_n),
  .sram_ce2    (sram_ce2),
  .sram_we_n   (sram_we_n),
  .sram_oe_n   (sram_oe_n),
  .sram_addr   (sram_addr),
  .sram_dq_out (sram_dq_out),
  .sram_dq_oe  (sram_dq_oe)
);

// File: tb/sim_asram_ctrl.sv
`timescale 1ns/1ps
module sim_asram_ctrl;
  localparam int AW = 5;
  localparam int DW = 8;
  localparam int NW = 1 << AW;

  function automatic int cyc(input int t, input int p);
    int c;
    c = (t + p - 1) / p;
    return (c < 1) ? 1 : c;
  endfunction

  // Expected counts for u0 (8 ns clock, 100/100/35/100/75/40/5 ns).
  localparam int AA_E  = cyc(100, 8);
  localparam int RD_E  = (cyc(100, 8) > AA_E) ? cyc(100, 8) : AA_E;
  localparam int HZ_E  = cyc(35, 8);
  localparam int WPT_E = cyc(75, 8);
  localparam int DS_E  = cyc(40, 8);
  localparam int WP_E  = (WPT_E > DS_E) ? WPT_E : DS_E;
  localparam int REC_E = ((cyc(100, 8) - WP_E) > cyc(5, 8)) ? (cyc(100, 8) - WP_E) : cyc(5, 8);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready, rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic          ce1_n, ce2, we_n, oe_n, dq_oe;
  logic [AW-1:0] sram_addr;
  logic [DW-1:0] dq_out;
  logic [DW-1:0] dq_in = '0;

  asram_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CLK_NS(8)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .sram_ce1_n(ce1_n), .sram_ce2(ce2), .sram_we_n(we_n), .sram_oe_n(oe_n),
    .sram_addr(sram_addr), .sram_dq_out(dq_out), .sram_dq_oe(dq_oe), .sram_dq_in(dq_in)
  );

  // Second instance, 20 ns timing basis, write cycle 60 ns: exercises rounding.
  logic          v1 = 1'b0, w1 = 1'b0;
  logic          rdy1, ack1, c1a, c1b, we1, oe1, doe1;
  logic [DW-1:0] rd1, do1;
  logic [AW-1:0] a1;
  asram_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CLK_NS(20), .T_WC_NS(60)) u1 (
    .clk(clk), .rst_n(rst_n), .req_valid(v1), .req_ready(rdy1),
    .req_write(w1), .req_addr(5'd3), .req_wdata(8'h11),
    .rsp_valid(ack1), .rsp_rdata(rd1),
    .sram_ce1_n(c1a), .sram_ce2(c1b), .sram_we_n(we1), .sram_oe_n(oe1),
    .sram_addr(a1), .sram_dq_out(do1), .sram_dq_oe(doe1), .sram_dq_in(8'h5A)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // RAM model evaluated at falling edges.
  logic [DW-1:0] mem [NW];
  int rd_age = 0, hz_age = 1000, wr_age = 0, ds_age = 0, ds_prev = 0;
  int cont_err = 0, wr_err = 0, wr_commits = 0;
  bit rd_prev = 0, wr_prev = 0, oe_prev = 0;
  logic [AW-1:0] addr_prev = '0;
  logic [DW-1:0] dout_prev = '0;

  initial for (int i = 0; i < NW; i++) mem[i] = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      bit rd_now, wr_now, drv;
      rd_now = !ce1_n && ce2 && !oe_n && we_n;
      wr_now = !ce1_n && ce2 && !we_n;
      if (rd_now && rd_prev && sram_addr == addr_prev) rd_age++;
      else rd_age = rd_now ? 1 : 0;
      if (rd_now) hz_age = 0;
      else if (hz_age < 1000) hz_age++;
      drv = rd_now || (hz_age > 0 && hz_age <= HZ_E);
      if (dq_oe && drv) cont_err++;
      dq_in = rd_now ? ((rd_age >= AA_E) ? mem[sram_addr] : ~mem[sram_addr]) : 8'h00;
      ds_prev = ds_age;
      if (dq_oe && oe_prev && dq_out == dout_prev) ds_age++;
      else ds_age = dq_oe ? 1 : 0;
      if (wr_now) wr_age = wr_prev ? wr_age + 1 : 1;
      if (wr_prev && !wr_now) begin
        if (wr_age >= WPT_E && ds_prev >= DS_E && sram_addr == addr_prev && dq_oe) begin
          mem[addr_prev] = dout_prev;
          wr_commits++;
        end else wr_err++;
      end
      rd_prev = rd_now; wr_prev = wr_now; oe_prev = dq_oe;
      addr_prev = sram_addr; dout_prev = dq_out;
    end
  end

  logic [DW-1:0] shadow [NW];
  int n_writes = 0;

  // One access through u0, inputs scrambled while busy (R2).
  task automatic op(input bit wr, input int a, input int d);
    int lat, ack_lat, rdy_lat, acks;
    logic [DW-1:0] got;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = AW'(a); req_wdata = DW'(d);
    @(negedge clk);
    req_valid = 1'b0; req_write = ~wr; req_addr = ~AW'(a); req_wdata = ~DW'(d);
    lat = 0; ack_lat = -1; rdy_lat = -1; acks = 0; got = '0;
    while (lat < 100) begin
      if (rsp_valid) begin
        acks++;
        if (ack_lat < 0) begin ack_lat = lat; got = rsp_rdata; end
      end
      if (req_ready && rdy_lat < 0) rdy_lat = lat;
      if (rdy_lat >= 0 && ack_lat >= 0 && lat > ack_lat) break;
      @(negedge clk);
      lat++;
    end
    if (wr) begin
      shadow[a] = DW'(d);
      n_writes++;
      // R7 R10 write completion and ready latency
      chk(ack_lat == WP_E + REC_E, "R7 write ack latency", ack_lat, WP_E + REC_E);
      chk(rdy_lat == WP_E + REC_E, "R7 write ready latency", rdy_lat, WP_E + REC_E);
    end else begin
      // R3 R10 read latency and data
      chk(ack_lat == RD_E, "R3 read ack latency", ack_lat, RD_E);
      chk(got == shadow[a], "R3 read data", int'(got), int'(shadow[a]));
      // R4 turnaround before ready
      chk(rdy_lat == RD_E + HZ_E, "R4 read ready latency", rdy_lat, RD_E + HZ_E);
    end
    // R9 exactly one pulse
    chk(acks == 1, "R9 single ack", acks, 1);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int lat;
    for (int i = 0; i < NW; i++) shadow[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ce1_n && !ce2 && we_n && oe_n && !dq_oe, "R1 standby in reset", 0, 1);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(req_ready && !rsp_valid && ce1_n && !ce2 && !dq_oe, "R1 idle after reset", int'(req_ready), 1);

    // Sweep 1: ascending write then ascending read.
    for (int a = 0; a < NW; a++) op(1'b1, a, (a * 29 + 7) & 255);
    for (int a = 0; a < NW; a++) op(1'b0, a, 0);
    // Sweep 2: descending with a different pattern.
    for (int a = NW - 1; a >= 0; a--) op(1'b1, a, ((a * 29 + 7) ^ 255 ^ a) & 255);
    for (int a = NW - 1; a >= 0; a--) op(1'b0, a, 0);
    // Sweep 3: back-to-back write/read and read/write turnarounds.
    for (int a = 0; a < NW; a++) begin
      op(1'b1, a, (a * a + 3) & 255);
      op(1'b0, a, 0);
      op(1'b1, (a + 1) % NW, (a * 5 + 200) & 255);
      op(1'b0, (a + 1) % NW, 0);
    end
    // R1 idle again after traffic
    @(negedge clk);
    chk(req_ready && ce1_n && !ce2 && we_n && oe_n && !dq_oe, "R1 idle after traffic", int'(dq_oe), 0);
    // R5 R6 model saw every write pulse and setup window met
    chk(wr_err == 0, "R5 write pulse or data setup short", wr_err, 0);
    chk(wr_commits == n_writes, "R7 writes committed", wr_commits, n_writes);
    // R6 bus never driven against the RAM output
    chk(cont_err == 0, "R6 bus contention", cont_err, 0);

    // R10: u1 at 20 ns basis, read 5 cycles, write 4+1 cycles.
    @(negedge clk); v1 = 1'b1; w1 = 1'b0;
    @(negedge clk); v1 = 1'b0; lat = 0;
    while (!ack1 && lat < 50) begin @(negedge clk); lat++; end
    chk(lat == cyc(100, 20), "R10 rounded read latency", lat, cyc(100, 20));
    chk(rd1 == 8'h5A, "R10 read data", int'(rd1), 'h5A);
    while (!rdy1) @(negedge clk);
    v1 = 1'b1; w1 = 1'b1;
    @(negedge clk); v1 = 1'b0; lat = 0;
    while (!ack1 && lat < 50) begin @(negedge clk); lat++; end
    chk(lat == cyc(75, 20) + 1, "R10 minimum one-cycle recovery", lat, cyc(75, 20) + 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule